// File: doc/BRIEF.md
# Cache Hardware Flush Sequencer

This block empties a two-way set-associative cache in hardware. Software sets a start bit. The sequencer then reads every tag entry through a shared tag-RAM port. For every modified sector of a valid line, it raises one castout request carrying the way, index and sector. When all entries have been visited, it writes every tag entry to the invalid value, clears the start bit and releases the cache.

The walk order is fixed. It visits every index of way 0 in ascending order, then every index of way 1. Within a line, sectors are visited from sector 0 upward. Each sector is 32 bytes; the number of sectors per line and the number of indices are parameters. While the sequencer is working, it holds a blocking output high so that L1 instruction and data requests stay away from the cache. Snoop lookups keep full service during this time, because a snoop strobe always takes the tag port ahead of the walk.

When the sequencer is idle, a global-invalidate request runs only the invalidation pass, with no castouts. While a flush or an invalidation is in progress, the global-invalidate request is ignored. The start bit returning to 0 means only that the tags are clean. It does not mean that castouts queued downstream have reached the bus.

Top module: `flush_seq`

## Requirements
- R1: After synchronous reset, `flush_bit`, `l1_block` and `co_req` are all 0.
- R2: A `flush_set` pulse while idle makes `flush_bit` and `l1_block` read 1 after the next clock edge.
- R3: The tag word has bit NUM_SECT as the valid flag and bit s as the modified flag of sector s. Castouts are raised in a fixed order:
  - way 0 indices 0 to NUM_IDX-1, then way 1 indices 0 to NUM_IDX-1;
  - within a line, ascending sector number;
  - exactly one castout per modified sector of a valid line;
  - none for invalid lines, whatever their modified bits.
- R4: A raised castout keeps `co_req`, `co_way`, `co_idx` and `co_sect` steady until `co_ack` is sampled high. The walk does not move on while acknowledge is low.
- R5: After the walk, every tag entry of both ways is written to all zeros (invalid), so a later snoop of any entry reports not valid.
- R6: On completion, `flush_bit` and `l1_block` fall on the same edge, with no castout outstanding.
- R7: `l1_block` is high from the start of a flush or invalidation until its completion, covering every castout and tag write.
- R8: A `snoop_req` strobe takes the tag port for a read in that cycle, blocking any walk write. `snoop_rsp_vld` is high two edges later, carrying the entry's valid and modified bits. The walk resumes at the same way, index and sector.
- R9: `inval_req` during a flush is ignored: the flush still raises its full castout list and `flush_bit` stays 1.
- R10: `inval_req` while idle invalidates every entry with no castouts; `l1_block` goes high after the next edge while `flush_bit` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_set | input | 1 | Software write of 1 to the flush start bit |
| inval_req | input | 1 | Global-invalidate request |
| flush_bit | output | 1 | Flush start bit, cleared by hardware on completion |
| l1_block | output | 1 | Blocks L1 instruction and data requests |
| tag_rd_en | output | 1 | Tag-RAM read enable (data next cycle) |
| tag_wr_en | output | 1 | Tag-RAM write enable |
| tag_way | output | 1 | Tag-RAM way select |
| tag_idx | output | $clog2(NUM_IDX) | Tag-RAM index |
| tag_wdata | output | NUM_SECT+1 | Tag write data |
| tag_rdata | input | NUM_SECT+1 | Tag read data, {valid, modified[NUM_SECT-1:0]} |
| co_req | output | 1 | Castout request |
| co_way | output | 1 | Castout way |
| co_idx | output | $clog2(NUM_IDX) | Castout index |
| co_sect | output | $clog2(NUM_SECT) | Castout sector |
| co_ack | input | 1 | Castout acknowledge |
| snoop_req | input | 1 | One-cycle snoop lookup strobe |
| snoop_way | input | 1 | Snoop way |
| snoop_idx | input | $clog2(NUM_IDX) | Snoop index |
| snoop_rsp_vld | output | 1 | Snoop response strobe |
| snoop_rsp_valid | output | 1 | Valid flag of the snooped entry |
| snoop_rsp_dirty | output | NUM_SECT | Modified flags of the snooped entry |

## Verification
The start bit and the blocking output are due one edge after the `flush_set` or `inval_req` pulse. The bench drives each pulse at a falling edge and reads the outputs at the next falling edge. A snoop response is due exactly two edges after its strobe, so the bench reads it at the second falling edge after driving the strobe; it does this in the middle of a flush, while `inval_req` is also pulsed. Castout timing depends on the acknowledge delay, so castouts are logged at the falling edge where acknowledge is driven and compared as an ordered list against a walk of the bench's own tag model. Completion is polled at falling edges, with a bound on the wait. Runs are made with immediate acknowledge and with a three-cycle acknowledge delay.

// File: rtl/flush_seq_pkg.sv
package flush_seq_pkg;
  typedef enum logic [2:0] {
    FS_IDLE,
    FS_READ,
    FS_CAPT,
    FS_SCAN,
    FS_INVAL
  } fs_state_e;

  function automatic int ptr_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/flush_walk_ctr.sv
module flush_walk_ctr #(
  parameter int NUM_IDX = 16,
  localparam int IW = flush_seq_pkg::ptr_bits(NUM_IDX)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  output logic          way,
  output logic [IW-1:0] idx,
  output logic          at_end
);
  localparam logic [IW-1:0] IDX_MAX = IW'(NUM_IDX - 1);

  assign at_end = way && (idx == IDX_MAX);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      way <= 1'b0;
      idx <= '0;
    end else if (step) begin
      if (idx == IDX_MAX) begin
        idx <= '0;
        way <= ~way;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/flush_sect_scan.sv
module flush_sect_scan #(
  parameter int NUM_SECT = 4,
  localparam int SW = flush_seq_pkg::ptr_bits(NUM_SECT)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [NUM_SECT-1:0] mask_in,
  input  logic                co_ack,
  output logic                co_req,
  output logic [SW-1:0]       co_sect,
  output logic                line_done
);
  localparam logic [SW-1:0] SECT_MAX = SW'(NUM_SECT - 1);

  logic [NUM_SECT-1:0] mask_q;
  logic                run_q;
  logic                adv;

  assign adv       = run_q && (co_req ? co_ack : !mask_q[co_sect]);
  assign line_done = adv && (co_sect == SECT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      run_q   <= 1'b0;
      co_req  <= 1'b0;
      co_sect <= '0;
    end else if (load) begin
      mask_q  <= mask_in;
      run_q   <= 1'b1;
      co_req  <= 1'b0;
      co_sect <= '0;
    end else if (run_q) begin
      if (co_req) begin
        if (co_ack) co_req <= 1'b0;
      end else if (mask_q[co_sect]) begin
        co_req <= 1'b1;
      end
      if (adv) begin
        if (co_sect == SECT_MAX) run_q <= 1'b0;
        else                     co_sect <= co_sect + 1'b1;
      end
    end
  end
endmodule

// File: rtl/flush_tag_port.sv
module flush_tag_port #(
  parameter int NUM_IDX  = 16,
  parameter int NUM_SECT = 4,
  localparam int IW = flush_seq_pkg::ptr_bits(NUM_IDX),
  localparam int TW = NUM_SECT + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                snoop_req,
  input  logic                snoop_way,
  input  logic [IW-1:0]       snoop_idx,
  input  logic                walk_rd,
  input  logic                walk_wr,
  input  logic                walk_way,
  input  logic [IW-1:0]       walk_idx,
  output logic                walk_gnt,
  output logic                tag_rd_en,
  output logic                tag_wr_en,
  output logic                tag_way,
  output logic [IW-1:0]       tag_idx,
  output logic [TW-1:0]       tag_wdata,
  input  logic [TW-1:0]       tag_rdata,
  output logic                rsp_vld,
  output logic                rsp_valid,
  output logic [NUM_SECT-1:0] rsp_dirty
);
  logic snp_q;

  always_comb begin
    walk_gnt  = !snoop_req;
    tag_rd_en = snoop_req || walk_rd;
    tag_wr_en = !snoop_req && walk_wr;
    tag_way   = snoop_req ? snoop_way : walk_way;
    tag_idx   = snoop_req ? snoop_idx : walk_idx;
    tag_wdata = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snp_q     <= 1'b0;
      rsp_vld   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_dirty <= '0;
    end else begin
      snp_q   <= snoop_req;
      rsp_vld <= snp_q;
      if (snp_q) begin
        rsp_valid <= tag_rdata[NUM_SECT];
        rsp_dirty <= tag_rdata[NUM_SECT-1:0];
      end
    end
  end
endmodule

// File: rtl/flush_seq.sv
module flush_seq
  import flush_seq_pkg::*;
#(
  parameter int NUM_IDX  = 16,
  parameter int NUM_SECT = 4,
  localparam int IW = ptr_bits(NUM_IDX),
  localparam int SW = ptr_bits(NUM_SECT),
  localparam int TW = NUM_SECT + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flush_set,
  input  logic                inval_req,
  output logic                flush_bit,
  output logic                l1_block,
  output logic                tag_rd_en,
  output logic                tag_wr_en,
  output logic                tag_way,
  output logic [IW-1:0]       tag_idx,
  output logic [TW-1:0]       tag_wdata,
  input  logic [TW-1:0]       tag_rdata,
  output logic                co_req,
  output logic                co_way,
  output logic [IW-1:0]       co_idx,
  output logic [SW-1:0]       co_sect,
  input  logic                co_ack,
  input  logic                snoop_req,
  input  logic                snoop_way,
  input  logic [IW-1:0]       snoop_idx,
  output logic                snoop_rsp_vld,
  output logic                snoop_rsp_valid,
  output logic [NUM_SECT-1:0] snoop_rsp_dirty
);
  fs_state_e           st_q;
  logic                walk_way;
  logic [IW-1:0]       walk_idx;
  logic                walk_end;
  logic                walk_clr;
  logic                walk_step;
  logic                walk_gnt;
  logic                line_done;
  logic                scan_load;
  logic [NUM_SECT-1:0] line_mask;

  assign walk_clr  = (st_q == FS_IDLE) && (flush_set || inval_req);
  assign walk_step = ((st_q == FS_SCAN) && line_done) ||
                     ((st_q == FS_INVAL) && walk_gnt);
  assign scan_load = (st_q == FS_CAPT);
  assign line_mask = tag_rdata[NUM_SECT] ? tag_rdata[NUM_SECT-1:0] : '0;
  assign co_way    = walk_way;
  assign co_idx    = walk_idx;

  flush_walk_ctr #(.NUM_IDX(NUM_IDX)) u_walk (
    .clk    (clk),
    .rst    (rst),
    .clr    (walk_clr),
    .step   (walk_step),
    .way    (walk_way),
    .idx    (walk_idx),
    .at_end (walk_end)
  );

  flush_sect_scan #(.NUM_SECT(NUM_SECT)) u_scan (
    .clk       (clk),
    .rst       (rst),
    .load      (scan_load),
    .mask_in   (line_mask),
    .co_ack    (co_ack),
    .co_req    (co_req),
    .co_sect   (co_sect),
    .line_done (line_done)
  );

  flush_tag_port #(.NUM_IDX(NUM_IDX), .NUM_SECT(NUM_SECT)) u_port (
    .clk       (clk),
    .rst       (rst),
    .snoop_req (snoop_req),
    .snoop_way (snoop_way),
    .snoop_idx (snoop_idx),
    .walk_rd   (st_q == FS_READ),
    .walk_wr   (st_q == FS_INVAL),
    .walk_way  (walk_way),
    .walk_idx  (walk_idx),
    .walk_gnt  (walk_gnt),
    .tag_rd_en (tag_rd_en),
    .tag_wr_en (tag_wr_en),
    .tag_way   (tag_way),
    .tag_idx   (tag_idx),
    .tag_wdata (tag_wdata),
    .tag_rdata (tag_rdata),
    .rsp_vld   (snoop_rsp_vld),
    .rsp_valid (snoop_rsp_valid),
    .rsp_dirty (snoop_rsp_dirty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= FS_IDLE;
      flush_bit <= 1'b0;
      l1_block  <= 1'b0;
    end else begin
      unique case (st_q)
        FS_IDLE: begin
          if (flush_set) begin
            st_q      <= FS_READ;
            flush_bit <= 1'b1;
            l1_block  <= 1'b1;
          end else if (inval_req) begin
            st_q     <= FS_INVAL;
            l1_block <= 1'b1;
          end
        end
        FS_READ:  if (walk_gnt) st_q <= FS_CAPT;
        FS_CAPT:  st_q <= FS_SCAN;
        FS_SCAN: begin
          if (line_done) st_q <= walk_end ? FS_INVAL : FS_READ;
        end
        FS_INVAL: begin
          if (walk_gnt && walk_end) begin
            st_q      <= FS_IDLE;
            flush_bit <= 1'b0;
            l1_block  <= 1'b0;
          end
        end
        default: st_q <= FS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flush_seq_chk.sv
module flush_seq_chk #(
  parameter int IW = 4,
  parameter int SW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          flush_bit,
  input logic          l1_block,
  input logic          tag_wr_en,
  input logic          co_req,
  input logic          co_way,
  input logic [IW-1:0] co_idx,
  input logic [SW-1:0] co_sect,
  input logic          co_ack,
  input logic          snoop_req,
  input logic          snoop_rsp_vld
);
  p_co_hold_r4: assert property (@(posedge clk) disable iff (rst)
    co_req && !co_ack |=> co_req && $stable(co_way) && $stable(co_idx) && $stable(co_sect));

  p_co_blocked_r7: assert property (@(posedge clk) disable iff (rst)
    co_req |-> l1_block);

  p_wr_blocked_r7: assert property (@(posedge clk) disable iff (rst)
    tag_wr_en |-> l1_block);

  p_snoop_rsp_r8: assert property (@(posedge clk) disable iff (rst)
    snoop_req |-> ##2 snoop_rsp_vld);

  p_snoop_port_r8: assert property (@(posedge clk) disable iff (rst)
    snoop_req |-> !tag_wr_en);

  p_done_together_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(flush_bit) |-> $fell(l1_block) && !co_req);
endmodule

bind flush_seq flush_seq_chk #(.IW(IW), .SW(SW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .flush_bit     (flush_bit),
  .l1_block      (l1_block),
  .tag_wr_en     (tag_wr_en),
  .co_req        (co_req),
  .co_way        (co_way),
  .co_idx        (co_idx),
  .co_sect       (co_sect),
  .co_ack        (co_ack),
  .snoop_req     (snoop_req),
  .snoop_rsp_vld (snoop_rsp_vld)
);

// File: tb/flush_seq_tb.sv
module flush_seq_tb;
  localparam int NI = 16;
  localparam int NS = 4;
  localparam int IW = 4;
  localparam int SW = 2;
  localparam int TW = NS + 1;

  // preload vectors {way, idx, tag word}; expected castouts follow from them
  localparam int NPRE = 8;
  localparam logic [9:0] PRE [NPRE] = '{
    {1'b1, 4'd3,  5'b10101}, {1'b0, 4'd15, 5'b11000},
    {1'b0, 4'd0,  5'b10001}, {1'b1, 4'd0,  5'b11111},
    {1'b0, 4'd7,  5'b00110}, {1'b0, 4'd2,  5'b10000},
    {1'b1, 4'd15, 5'b10010}, {1'b1, 4'd8,  5'b11001}
  };

  logic clk = 0, rst = 1;
  logic flush_set = 0, inval_req = 0;
  logic flush_bit, l1_block;
  logic tag_rd_en, tag_wr_en, tag_way;
  logic [IW-1:0] tag_idx;
  logic [TW-1:0] tag_wdata, tag_rdata;
  logic co_req, co_way, co_ack = 0;
  logic [IW-1:0] co_idx;
  logic [SW-1:0] co_sect;
  logic snoop_req = 0, snoop_way = 0;
  logic [IW-1:0] snoop_idx = '0;
  logic snoop_rsp_vld, snoop_rsp_valid;
  logic [NS-1:0] snoop_rsp_dirty;

  logic pl_en = 0, pl_way = 0;
  logic [IW-1:0] pl_idx = '0;
  logic [TW-1:0] pl_data = '0;
  logic [TW-1:0] mem [0:1][0:NI-1];
  logic [TW-1:0] gmem [0:1][0:NI-1];

  int ack_delay = 0;
  int wait_n = 0;
  logic [6:0] log_q [0:255];
  int log_n = 0;
  logic [6:0] exp_q [0:255];
  int exp_n;
  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  flush_seq #(.NUM_IDX(NI), .NUM_SECT(NS)) u_dut (
    .clk(clk), .rst(rst), .flush_set(flush_set), .inval_req(inval_req),
    .flush_bit(flush_bit), .l1_block(l1_block),
    .tag_rd_en(tag_rd_en), .tag_wr_en(tag_wr_en), .tag_way(tag_way),
    .tag_idx(tag_idx), .tag_wdata(tag_wdata), .tag_rdata(tag_rdata),
    .co_req(co_req), .co_way(co_way), .co_idx(co_idx), .co_sect(co_sect),
    .co_ack(co_ack), .snoop_req(snoop_req), .snoop_way(snoop_way),
    .snoop_idx(snoop_idx), .snoop_rsp_vld(snoop_rsp_vld),
    .snoop_rsp_valid(snoop_rsp_valid), .snoop_rsp_dirty(snoop_rsp_dirty)
  );

  // tag RAM model, one-cycle read latency
  always_ff @(posedge clk) begin
    if (pl_en) mem[pl_way][pl_idx] <= pl_data;
    else if (tag_wr_en) mem[tag_way][tag_idx] <= tag_wdata;
    if (tag_rd_en) tag_rdata <= mem[tag_way][tag_idx];
  end

  // castout acknowledger and logger
  always @(negedge clk) begin
    if (rst) begin
      co_ack = 0;
      wait_n = ack_delay;
    end else if (co_ack) begin
      co_ack = 0;
      wait_n = ack_delay;
    end else if (co_req) begin
      if (wait_n == 0) begin
        co_ack = 1;
        log_q[log_n[7:0]] = {co_way, co_idx, co_sect};
        log_n++;
      end else begin
        wait_n--;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic preload();
    for (int w = 0; w < 2; w++)
      for (int i = 0; i < NI; i++) begin
        gmem[w][i] = '0;
        @(negedge clk);
        pl_en = 1; pl_way = w[0]; pl_idx = IW'(i); pl_data = '0;
      end
    for (int k = 0; k < NPRE; k++) begin
      @(negedge clk);
      pl_en = 1; pl_way = PRE[k][9]; pl_idx = PRE[k][8:5]; pl_data = PRE[k][4:0];
      gmem[PRE[k][9]][PRE[k][8:5]] = PRE[k][4:0];
    end
    @(negedge clk);
    pl_en = 0;
    exp_n = 0;
    for (int w = 0; w < 2; w++)
      for (int i = 0; i < NI; i++)
        for (int s = 0; s < NS; s++)
          if (gmem[w][i][NS] && gmem[w][i][s]) begin
            exp_q[exp_n] = {w[0], i[IW-1:0], s[SW-1:0]};
            exp_n++;
          end
  endtask

  task automatic wait_idle();
    for (int c = 0; c < 5000 && l1_block; c++) @(negedge clk);
  endtask

  task automatic check_all_invalid(input string req);
    int bad = 0;
    for (int w = 0; w < 2; w++)
      for (int i = 0; i < NI; i++)
        if (mem[w][i] != '0) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic run_flush(input int dly);
    int base;
    ack_delay = dly;
    preload();
    base = log_n;
    flush_set = 1;
    @(negedge clk);
    flush_set = 0;
    chk(flush_bit == 1, "R2 start bit", flush_bit, 1);
    chk(l1_block == 1, "R2 block", l1_block, 1);
    for (int c = 0; c < 2000 && (log_n - base) < 2; c++) @(negedge clk);
    // snoop a clean valid line mid-flush, with an invalidate request alongside
    snoop_req = 1; snoop_way = 0; snoop_idx = 4'd2; inval_req = 1;
    @(negedge clk);
    snoop_req = 0; inval_req = 0;
    @(negedge clk);
    chk(snoop_rsp_vld == 1, "R8 rsp strobe", snoop_rsp_vld, 1);
    chk(snoop_rsp_valid == 1, "R8 rsp valid", snoop_rsp_valid, 1);
    chk(snoop_rsp_dirty == '0, "R8 rsp dirty", snoop_rsp_dirty, 0);
    chk(l1_block == 1, "R7 blocked mid-flush", l1_block, 1);
    chk(flush_bit == 1, "R9 flush kept", flush_bit, 1);
    wait_idle();
    chk(l1_block == 0, "R6 completion", l1_block, 0);
    chk(flush_bit == 0, "R6 start bit cleared", flush_bit, 0);
    chk(co_req == 0, "R6 no castout left", co_req, 0);
    chk(log_n - base == exp_n, "R3 R9 castout count", log_n - base, exp_n);
    for (int k = 0; k < exp_n; k++)
      chk(log_q[base + k] == exp_q[k], "R3 R4 castout order",
          int'(log_q[base + k]), int'(exp_q[k]));
    check_all_invalid("R5 tags invalid");
    snoop_req = 1; snoop_way = 1; snoop_idx = 4'd0;
    @(negedge clk);
    snoop_req = 0;
    @(negedge clk);
    chk(snoop_rsp_vld && !snoop_rsp_valid, "R5 snoop after flush", snoop_rsp_valid, 0);
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    chk(flush_bit == 0, "R1 start bit", flush_bit, 0);
    chk(l1_block == 0, "R1 block", l1_block, 0);
    chk(co_req == 0, "R1 castout", co_req, 0);
    rst = 0;
    @(negedge clk);

    run_flush(0);
    run_flush(3);

    // idle global invalidate: R10
    preload();
    base = log_n;
    inval_req = 1;
    @(negedge clk);
    inval_req = 0;
    chk(l1_block == 1, "R10 block", l1_block, 1);
    chk(flush_bit == 0, "R10 start bit stays 0", flush_bit, 0);
    wait_idle();
    chk(l1_block == 0, "R10 completion", l1_block, 0);
    chk(log_n == base, "R10 no castouts", log_n - base, 0);
    check_all_invalid("R10 tags invalid");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule